// File: doc/BRIEF.md
# Data-Space Address Router with External Byte-Bus Sequencer

This block sits between a core's load/store unit and the things that live in its 64 KiB data space. Each accepted request carries a 16-bit address, a direction and a write byte. The block sorts the address into one of five targets: the register file, the standard I/O window, the extended I/O window, on-chip SRAM, or off-chip SRAM. For an on-chip target it raises that target's select output for one cycle, together with a completion pulse, in the cycle after acceptance. For an off-chip target it runs a byte-wide bus cycle. The bus cycle uses active-low read and write strobes and a programmable number of wait states. It then returns a completion pulse and the captured read byte.

A mode input chooses between two memory maps. The full map places the 160-byte extended I/O window at 0x0060–0x00FF and 4096 bytes of SRAM at 0x0100–0x10FF, so off-chip space starts at 0x1100. The reduced map has no extended I/O window. In that map SRAM fills 0x0060–0x0FFF (4000 bytes) and off-chip space starts at 0x1000. Off-chip access also needs an enable input. Without it, an off-chip address completes at once with an error flag. The requester sees off-chip and on-chip accesses through one interface, and they differ only in how long completion takes.

Top module: `dspace_router`

## Requirements
- R1: While and after reset, with no request, `bus_rd_n` and `bus_wr_n` are 1 and `done`, `err`, `busy`, `rdata` and all four selects are 0.
- R2: With `compat_mode`=0, an accepted request to 0x0000–0x001F raises `sel_regs`, 0x0020–0x005F raises `sel_stdio`, 0x0060–0x00FF raises `sel_extio` and 0x0100–0x10FF raises `sel_sram`. The select is high for exactly one cycle, the cycle after the acceptance edge, together with `done`.
- R3: With `compat_mode`=1, 0x0000–0x001F raises `sel_regs`, 0x0020–0x005F raises `sel_stdio` and 0x0060–0x0FFF raises `sel_sram`. `sel_extio` is never raised in this mode.
- R4: Addresses from the off-chip base (0x1100 with `compat_mode`=0, 0x1000 with `compat_mode`=1) up to 0xFFFF start a bus cycle when `xmem_en`=1. `bus_addr` carries the request address for the whole strobe, and no select is raised.
- R5: Let W be the wait-state count. An enabled off-chip access raises `done` in the cycle W+1 cycles after the one in which an on-chip access would raise it. That is one extra cycle for W=0, and 2, 3 or 4 extra cycles for W=1, 2 or 3.
- R6: During an off-chip access the strobe matching the direction (`bus_rd_n` for reads, `bus_wr_n` for writes) is low for exactly W+1 consecutive cycles, starting the cycle after acceptance. The other strobe stays 1, and both strobes are never low together.
- R7: On an off-chip read, `rdata` equals the `bus_rdata` value present in the last strobe cycle, and is valid in the `done` cycle. In every other cycle `rdata` is 0x00.
- R8: On an off-chip write, `bus_wdata` carries the request write byte, and `bus_addr` and `bus_wdata` are stable for every strobe cycle.
- R9: `wait_cfg` is sampled at acceptance. A change to it during an off-chip access does not alter that access's strobe length or latency.
- R10: An off-chip address with `xmem_en`=0 asserts no strobe and no select. It raises `done` and `err` for one cycle in the cycle after acceptance, with `rdata`=0x00.
- R11: `busy` is 1 exactly while a bus cycle's strobe is active. A request presented while `busy`=1 is dropped and produces no `done`.
- R12: Both strobes stay 1 for the whole of every access to an on-chip target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted on a rising edge when `busy`=0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space byte address |
| req_wdata | input | 8 | Write byte |
| compat_mode | input | 1 | 0 = full map with extended I/O, 1 = reduced map |
| xmem_en | input | 1 | Enables off-chip accesses |
| wait_cfg | input | 2 | Wait-state count 0–3, sampled at acceptance |
| busy | output | 1 | Off-chip bus cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle flag: off-chip access while disabled |
| rdata | output | 8 | Off-chip read byte, valid with `done` |
| sel_regs | output | 1 | Register-file select pulse |
| sel_stdio | output | 1 | Standard I/O select pulse |
| sel_extio | output | 1 | Extended I/O select pulse |
| sel_sram | output | 1 | On-chip SRAM select pulse |
| bus_addr | output | 16 | Off-chip bus address |
| bus_wdata | output | 8 | Off-chip bus write byte |
| bus_rdata | input | 8 | Off-chip bus read byte |
| bus_rd_n | output | 1 | Off-chip read strobe, active low |
| bus_wr_n | output | 1 | Off-chip write strobe, active low |

## Verification
The properties assume that `req_valid`, `req_addr`, `compat_mode` and `xmem_en` are known values at every rising edge after reset. They also assume that the map and enable inputs seen at acceptance are the ones used to judge the address region. The driver changes inputs only on falling edges and holds every request field steady across its acceptance edge. It lets `busy` fall before it issues the next request, except for one deliberate single-cycle request placed inside a bus cycle. `bus_rdata` is always driven, as a fixed function of `bus_addr`, so the captured read byte is defined in every strobe cycle.

// File: rtl/dspace_pkg.sv
package dspace_pkg;
    // Target classes; the first four index the select vector
    typedef enum logic [2:0] {
        TGT_REGS  = 3'd0,
        TGT_STDIO = 3'd1,
        TGT_EXTIO = 3'd2,
        TGT_SRAM  = 3'd3,
        TGT_XMEM  = 3'd4
    } tgt_e;

    localparam int SEL_N = 4;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUS  = 1'b1
    } phase_e;
endpackage

// File: rtl/dspace_region_dec.sv
module dspace_region_dec
    import dspace_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int REGS_BYTES  = 32,
    parameter int STDIO_BYTES = 64,
    parameter int EXTIO_BYTES = 160,
    parameter int SRAM_FULL   = 4096,
    parameter int SRAM_RED    = 4000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              reduced,
    output tgt_e              tgt
);
    localparam int unsigned STDIO_LO  = REGS_BYTES;
    localparam int unsigned EXTIO_LO  = STDIO_LO + STDIO_BYTES;
    localparam int unsigned SRAM_LO_F = EXTIO_LO + EXTIO_BYTES;
    localparam int unsigned XMEM_LO_F = SRAM_LO_F + SRAM_FULL;
    localparam int unsigned XMEM_LO_R = EXTIO_LO + SRAM_RED;

    logic [31:0] a_wide;
    logic [31:0] xmem_lo;

    always_comb begin
        a_wide  = 32'(addr);
        xmem_lo = reduced ? 32'(XMEM_LO_R) : 32'(XMEM_LO_F);
        if (a_wide < 32'(STDIO_LO)) begin
            tgt = TGT_REGS;
        end else if (a_wide < 32'(EXTIO_LO)) begin
            tgt = TGT_STDIO;
        end else if (!reduced && (a_wide < 32'(SRAM_LO_F))) begin
            tgt = TGT_EXTIO;
        end else if (a_wide < xmem_lo) begin
            tgt = TGT_SRAM;
        end else begin
            tgt = TGT_XMEM;
        end
    end
endmodule

// File: rtl/dspace_wait_ctr.sv
module dspace_wait_ctr #(
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] load_val,
    input  logic            step,
    output logic            at_zero
);
    logic [WS_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/dspace_router.sv
module dspace_router
    import dspace_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int WS_W        = 2,
    parameter int REGS_BYTES  = 32,
    parameter int STDIO_BYTES = 64,
    parameter int EXTIO_BYTES = 160,
    parameter int SRAM_FULL   = 4096,
    parameter int SRAM_RED    = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              compat_mode,
    input  logic              xmem_en,
    input  logic [WS_W-1:0]   wait_cfg,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              sel_regs,
    output logic              sel_stdio,
    output logic              sel_extio,
    output logic              sel_sram,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd_n,
    output logic              bus_wr_n
);
    typedef struct packed {
        phase_e            phase;
        logic              is_wr;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
        logic [SEL_N-1:0]  sel;
        logic              rd_n;
        logic              wr_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } state_t;

    localparam state_t RESET_ST = '{
        phase: PH_IDLE, is_wr: 1'b0, done: 1'b0, err: 1'b0, rdata: '0,
        sel: '0, rd_n: 1'b1, wr_n: 1'b1, addr: '0, wdata: '0
    };

    state_t st_d, st_q;
    tgt_e   tgt;
    logic   accept;
    logic   ctr_load;
    logic   ctr_step;
    logic   ctr_zero;

    dspace_region_dec #(
        .ADDR_W      (ADDR_W),
        .REGS_BYTES  (REGS_BYTES),
        .STDIO_BYTES (STDIO_BYTES),
        .EXTIO_BYTES (EXTIO_BYTES),
        .SRAM_FULL   (SRAM_FULL),
        .SRAM_RED    (SRAM_RED)
    ) u_dec (
        .addr    (req_addr),
        .reduced (compat_mode),
        .tgt     (tgt)
    );

    dspace_wait_ctr #(
        .WS_W (WS_W)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (wait_cfg),
        .step     (ctr_step),
        .at_zero  (ctr_zero)
    );

    assign accept = req_valid && (st_q.phase == PH_IDLE);

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.err   = 1'b0;
        st_d.sel   = '0;
        st_d.rdata = '0;
        ctr_load   = 1'b0;
        ctr_step   = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    unique case (tgt)
                        TGT_REGS:  begin st_d.done = 1'b1; st_d.sel[0] = 1'b1; end
                        TGT_STDIO: begin st_d.done = 1'b1; st_d.sel[1] = 1'b1; end
                        TGT_EXTIO: begin st_d.done = 1'b1; st_d.sel[2] = 1'b1; end
                        TGT_SRAM:  begin st_d.done = 1'b1; st_d.sel[3] = 1'b1; end
                        default: begin
                            if (xmem_en) begin
                                st_d.phase = PH_BUS;
                                st_d.is_wr = req_write;
                                st_d.rd_n  = req_write;
                                st_d.wr_n  = !req_write;
                                st_d.addr  = req_addr;
                                st_d.wdata = req_wdata;
                                ctr_load   = 1'b1;
                            end else begin
                                st_d.done = 1'b1;
                                st_d.err  = 1'b1;
                            end
                        end
                    endcase
                end
            end
            PH_BUS: begin
                if (ctr_zero) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.rd_n  = 1'b1;
                    st_d.wr_n  = 1'b1;
                    if (!st_q.is_wr) begin
                        st_d.rdata = bus_rdata;
                    end
                end else begin
                    ctr_step = 1'b1;
                end
            end
            default: st_d = RESET_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase == PH_BUS);
    assign done      = st_q.done;
    assign err       = st_q.err;
    assign rdata     = st_q.rdata;
    assign sel_regs  = st_q.sel[0];
    assign sel_stdio = st_q.sel[1];
    assign sel_extio = st_q.sel[2];
    assign sel_sram  = st_q.sel[3];
    assign bus_addr  = st_q.addr;
    assign bus_wdata = st_q.wdata;
    assign bus_rd_n  = st_q.rd_n;
    assign bus_wr_n  = st_q.wr_n;
endmodule

// File: rtl/dspace_router_chk.sv
module dspace_router_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int XMEM_LO_F = 4352,
    parameter int XMEM_LO_R = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              compat_mode,
    input logic              xmem_en,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [DATA_W-1:0] rdata,
    input logic              sel_regs,
    input logic              sel_stdio,
    input logic              sel_extio,
    input logic              sel_sram,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd_n,
    input logic              bus_wr_n
);
    logic        taken;
    logic        off_chip;
    logic [31:0] lo_bound;

    assign taken    = req_valid && !busy;
    assign lo_bound = compat_mode ? 32'(XMEM_LO_R) : 32'(XMEM_LO_F);
    assign off_chip = (32'(req_addr) >= lo_bound);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n)); // R6

    AST_ONCHIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !off_chip) |=> (done && bus_rd_n && bus_wr_n)); // R12

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_regs, sel_stdio, sel_extio, sel_sram})); // R2

    AST_SEL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_regs || sel_stdio || sel_extio || sel_sram) |-> (done && !err)); // R2

    AST_NO_EXTIO_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && compat_mode) |=> !sel_extio); // R3

    AST_OFFCHIP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && off_chip && xmem_en) |=> (busy && !done)); // R4

    AST_DISABLED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && off_chip && !xmem_en) |=> (err && done && !busy)); // R10

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (bus_rd_n && bus_wr_n && (rdata == '0))); // R10

    AST_STROBE_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> done); // R7

    AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bus_rd_n != bus_wr_n)); // R11

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_wdata))); // R8
endmodule

bind dspace_router dspace_router_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/tb_dspace_router.sv
`timescale 1ns/1ps
module tb_dspace_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        compat_mode = 1'b0;
    logic        xmem_en = 1'b0;
    logic [1:0]  wait_cfg = '0;
    logic        busy, done, err;
    logic [7:0]  rdata;
    logic        sel_regs, sel_stdio, sel_extio, sel_sram;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_rd_n, bus_wr_n;

    always #2.5 clk = ~clk;

    // off-chip memory model: read byte is a fixed function of the address
    assign bus_rdata = bus_addr[7:0] ^ 8'h5A;

    dspace_router dut (.*);

    typedef struct {
        logic [3:0]  sel;   // {regs, stdio, extio, sram}
        logic        err;
        logic [7:0]  rdata;
        int          due;
        int          rd_len;
        int          wr_len;
        logic [15:0] addr;
        logic [7:0]  wdata;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   rd_cnt = 0;
    int   wr_cnt = 0;
    logic [15:0] seen_addr = '0;
    logic [7:0]  seen_wdata = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // region code from the requirement address ranges: 0 regs,1 stdio,2 extio,3 sram,4 off-chip
    function automatic int region(input logic [15:0] a, input logic red);
        if (a < 16'h0020) return 0;
        if (a < 16'h0060) return 1;
        if (!red && a < 16'h0100) return 2;
        if (red ? (a < 16'h1000) : (a < 16'h1100)) return 3;
        return 4;
    endfunction

    task automatic access(input logic [15:0] a, input bit wr, input logic [7:0] wd,
                          input bit red, input bit en, input logic [1:0] ws,
                          input bit chg_ws, input bit poke);
        exp_t e;
        int   r;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        compat_mode = red; xmem_en = en; wait_cfg = ws;
        r = region(a, red);
        e.sel = 4'b0000; e.err = 1'b0; e.rdata = 8'h00; e.rd_len = 0; e.wr_len = 0;
        e.addr = a; e.wdata = wd;
        if (r < 4) e.sel[3 - r] = 1'b1;
        @(posedge clk);
        #1;
        e.due = cyc;
        if (r == 4) begin
            if (en) begin
                e.due = cyc + int'(ws) + 1;
                if (wr) e.wr_len = int'(ws) + 1;
                else begin
                    e.rd_len = int'(ws) + 1;
                    e.rdata  = a[7:0] ^ 8'h5A;
                end
            end else begin
                e.err = 1'b1;
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = poke;
        if (poke) req_addr = 16'h0003;
        if (chg_ws) wait_cfg = ~ws;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_rd_n) rd_cnt++;
            if (!bus_wr_n) wr_cnt++;
            if (!bus_rd_n || !bus_wr_n) begin
                seen_addr  = bus_addr;
                seen_wdata = bus_wdata;
            end
            if (!bus_rd_n && !bus_wr_n)
                check(1'b0, "R6 both strobes low", 2, 1);
            if (!done && (sel_regs || sel_stdio || sel_extio || sel_sram))
                check(1'b0, "R2 select without done", 1, 0);
            if (!done && rdata != 8'h00)
                check(1'b0, "R7 rdata outside done", int'(rdata), 0);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc == e.due, "R5 done cycle", cyc, e.due);
                    check({sel_regs, sel_stdio, sel_extio, sel_sram} == e.sel,
                          "R2/R3 r2_ r3_ select", int'({sel_regs, sel_stdio, sel_extio, sel_sram}), int'(e.sel));
                    check(err == e.err, "R10 err flag", int'(err), int'(e.err));
                    check(rdata == e.rdata, "R7 read data", int'(rdata), int'(e.rdata));
                    check(rd_cnt == e.rd_len, "R6 R9 R12 read strobe length", rd_cnt, e.rd_len);
                    check(wr_cnt == e.wr_len, "R6 R9 R12 write strobe length", wr_cnt, e.wr_len);
                    if (e.rd_len + e.wr_len > 0)
                        check(seen_addr == e.addr, "R4 bus address", int'(seen_addr), int'(e.addr));
                    if (e.wr_len > 0)
                        check(seen_wdata == e.wdata, "R8 bus write byte", int'(seen_wdata), int'(e.wdata));
                end
                rd_cnt = 0;
                wr_cnt = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check(bus_rd_n && bus_wr_n && !done && !err && !busy && rdata == 8'h00 &&
              !sel_regs && !sel_stdio && !sel_extio && !sel_sram, "R1 reset state", 0, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(bus_rd_n && bus_wr_n && !done && !busy, "R1 idle after reset", 0, 1);

        // R2: full map boundaries
        access(16'h0000, 0, 8'h00, 0, 1, 2'd0, 0, 0);
        access(16'h001F, 1, 8'h11, 0, 1, 2'd0, 0, 0);
        access(16'h0020, 0, 8'h00, 0, 1, 2'd0, 0, 0);
        access(16'h005F, 1, 8'h22, 0, 1, 2'd0, 0, 0);
        access(16'h0060, 0, 8'h00, 0, 1, 2'd0, 0, 0);
        access(16'h00FF, 0, 8'h00, 0, 1, 2'd0, 0, 0);
        access(16'h0100, 1, 8'h33, 0, 1, 2'd3, 0, 0);
        access(16'h10FF, 0, 8'h00, 0, 1, 2'd3, 0, 0);
        access(16'h1000, 0, 8'h00, 0, 1, 2'd1, 0, 0);   // still on-chip in the full map

        // R3: reduced map
        access(16'h005F, 0, 8'h00, 1, 1, 2'd0, 0, 0);
        access(16'h0060, 0, 8'h00, 1, 1, 2'd0, 0, 0);
        access(16'h00FF, 1, 8'h44, 1, 1, 2'd0, 0, 0);
        access(16'h0FFF, 0, 8'h00, 1, 1, 2'd2, 0, 0);

        // R4 R5 R6 R7 R8: off-chip, every wait count and both directions
        access(16'h1100, 0, 8'h00, 0, 1, 2'd0, 0, 0);
        access(16'h1234, 1, 8'hA5, 0, 1, 2'd1, 0, 0);
        access(16'h2345, 0, 8'h00, 0, 1, 2'd2, 0, 0);
        access(16'hFFFF, 1, 8'h3C, 0, 1, 2'd3, 0, 0);
        access(16'hFFFF, 0, 8'h00, 0, 1, 2'd3, 0, 0);
        access(16'h1000, 0, 8'h00, 1, 1, 2'd1, 0, 0);
        access(16'h1000, 1, 8'h7E, 1, 1, 2'd2, 0, 0);
        access(16'h10FF, 0, 8'h00, 1, 1, 2'd0, 0, 0);

        // R9: wait count changed during the access
        access(16'h4000, 0, 8'h00, 0, 1, 2'd0, 1, 0);
        access(16'h4001, 1, 8'h99, 0, 1, 2'd3, 1, 0);

        // R10: off-chip while disabled
        access(16'h1100, 0, 8'h00, 0, 0, 2'd3, 0, 0);
        access(16'h1000, 1, 8'h55, 1, 0, 2'd2, 0, 0);
        access(16'hFFFF, 0, 8'h00, 0, 0, 2'd0, 0, 0);

        // R11: request during a bus cycle is dropped
        access(16'h8000, 0, 8'h00, 0, 1, 2'd2, 0, 1);
        access(16'h8001, 1, 8'h0F, 0, 1, 2'd0, 0, 1);

        // back-to-back on-chip after off-chip
        access(16'h0040, 0, 8'h00, 0, 1, 2'd0, 0, 0);

        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R11 outstanding completions", exp_q.size(), 0);
        check(bus_rd_n && bus_wr_n && !busy, "R12 strobes idle at end", 0, 1);
        finish_run();
    end
endmodule